// File: doc/BRIEF.md
# HDLC Frame Receiver with Station Address Filter

This block turns a serial line into frames for a host. The line arrives one bit at a time, and a bit-clock enable marks each bit. The block looks for the flag pattern, removes the zeros the transmitter inserted after runs of five ones, and builds octets least-significant bit first. The first octet of each frame is the station address. That octet is checked against a programmable local address, and the all-ones broadcast address is always accepted. If filtering is on and the address matches neither, the frame is dropped silently.

Every later octet, including the control octet, goes to the host unchanged. Each octet appears as a one-cycle valid pulse, with markers for the first and last data octet. The block holds back the three most recent octets. Because of this, the two check-sequence octets that come before the closing flag are never shown as data.

When a frame closes, the block pulses a done strobe together with three status flags:
- the check-sequence verdict, based on a 16-bit CRC residue;
- a length/alignment error;
- an abort indication, raised when seven consecutive ones arrive in mid-frame.

Top module: `hdlc_addr_rx`

## Requirements
- R1: After reset no data or done strobe appears. Flags that enclose no complete address octet start a new frame each time and produce no output.
- R2: A 0 that follows five consecutive 1s inside a frame is deleted and is not counted as data. A 0 after six 1s is a flag (01111110 on the line).
- R3: The first octet after the opening flag is the address. The frame is accepted if filter_en is 0, if the address equals station_addr, or if it is 8'hFF. Otherwise the frame produces no data and no done strobe.
- R4: The octets of an accepted frame that follow the address are delivered in order and unchanged. Bit 0 of out_data is the first bit received. out_sof marks the first delivered octet and out_eof marks the last one. The last one is delivered in the cycle of frame_done.
- R5: The two octets just before the closing flag are the check sequence and are never delivered.
- R6: The CRC uses x^16+x^12+x^5+1, processed least-significant bit first, and is preset to all ones on every flag. fcs_ok is 1 at the closing flag exactly when the register holds 16'hF0B8.
- R7: Seven consecutive 1s inside an accepted frame pulse frame_done with frame_aborted=1 and fcs_ok=0, with no out_eof. The block then waits for a new flag.
- R8: len_err is 1 at close if the bit count after the address is not a multiple of 8, or if the frame has no data octet.
- R9: frame_done and its status flags are registered on the clock edge that samples the final 0 of the closing flag.
- R10: A closing flag also serves as the opening flag of the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Line bit present this cycle |
| rx_bit | input | 1 | Line bit value |
| station_addr | input | 8 | Local station address |
| filter_en | input | 1 | Enable address filtering |
| out_valid | output | 1 | Data octet strobe |
| out_data | output | 8 | Data octet |
| out_sof | output | 1 | First data octet of the frame |
| out_eof | output | 1 | Last data octet of the frame |
| frame_done | output | 1 | End-of-frame strobe |
| fcs_ok | output | 1 | Check sequence good (valid with frame_done) |
| len_err | output | 1 | Residue or too-short error (valid with frame_done) |
| frame_aborted | output | 1 | Frame ended by abort (valid with frame_done) |

## Verification
Every output is a register loaded on the edge that samples the deciding line bit. This means the last 0 of the closing flag, the seventh 1 of an abort, or the line bit that completes an octet three octets later. The result can be read half a clock later. The bench drives each bit on a falling edge and samples frame_done and its status on the next falling edge, which is the cycle R9 names. Delivered octets are collected on every falling edge. The octet queue is compared one clock after the closing flag, so the eof octet that shares the done cycle has already been collected.

// File: rtl/hdlc_addr_rx.sv
module hdlc_addr_rx #(
  parameter logic [15:0] CRC_POLY    = 16'h8408,
  parameter logic [15:0] CRC_PRESET  = 16'hFFFF,
  parameter logic [15:0] CRC_RESIDUE = 16'hF0B8,
  parameter logic [7:0]  BCAST_ADDR  = 8'hFF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_en,
  input  logic       rx_bit,
  input  logic [7:0] station_addr,
  input  logic       filter_en,
  output logic       out_valid,
  output logic [7:0] out_data,
  output logic       out_sof,
  output logic       out_eof,
  output logic       frame_done,
  output logic       fcs_ok,
  output logic       len_err,
  output logic       frame_aborted
);

  logic [2:0]  ones;
  logic        in_frame;
  logic        addr_seen;
  logic        sent;
  logic [6:0]  dly;
  logic [2:0]  fill;
  logic [7:0]  shreg;
  logic [2:0]  bitcnt;
  logic [15:0] crc;
  logic [1:0]  nb;
  logic [7:0]  h0, h1, h2;

  wire is_flag  = bit_en && !rx_bit && ones == 3'd6;
  wire is_abort = bit_en &&  rx_bit && ones == 3'd6;
  wire stuffed  = bit_en && !rx_bit && ones == 3'd5;
  wire push     = bit_en && in_frame && !is_flag && !is_abort && !stuffed;
  wire asm_v    = push && fill == 3'd7;
  wire asm_b    = dly[6];
  wire [7:0] byte_new = {asm_b, shreg[7:1]};
  wire byte_done = asm_v && bitcnt == 3'd7;
  wire [15:0] crc_nxt = {1'b0, crc[15:1]} ^ ((crc[0] ^ asm_b) ? CRC_POLY : 16'h0000);
  wire addr_ok = !filter_en || byte_new == station_addr || byte_new == BCAST_ADDR;
  wire closing = is_flag && in_frame && addr_seen;

  always_ff @(posedge clk) begin
    if (!rst_n) ones <= 3'd0;
    else if (bit_en) ones <= !rx_bit ? 3'd0 : (ones == 3'd7 ? 3'd7 : ones + 3'd1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_frame <= 1'b0;  addr_seen <= 1'b0; sent <= 1'b0;
      dly <= '0; fill <= '0; shreg <= '0; bitcnt <= '0;
      crc <= CRC_PRESET; nb <= '0;
      h0 <= '0; h1 <= '0; h2 <= '0;
      out_valid <= 1'b0; out_data <= '0; out_sof <= 1'b0; out_eof <= 1'b0;
      frame_done <= 1'b0; fcs_ok <= 1'b0; len_err <= 1'b0; frame_aborted <= 1'b0;
    end else begin
      out_valid  <= 1'b0;
      out_sof    <= 1'b0;
      out_eof    <= 1'b0;
      frame_done <= 1'b0;
      if (is_flag) begin
        if (closing) begin
          frame_done    <= 1'b1;
          fcs_ok        <= crc == CRC_RESIDUE;
          len_err       <= bitcnt != 3'd0 || nb != 2'd3;
          frame_aborted <= 1'b0;
          if (nb == 2'd3) begin
            out_valid <= 1'b1;
            out_data  <= h0;
            out_sof   <= !sent;
            out_eof   <= 1'b1;
          end
        end
        in_frame  <= 1'b1;
        addr_seen <= 1'b0;
        sent      <= 1'b0;
        fill      <= '0;
        bitcnt    <= '0;
        nb        <= '0;
        crc       <= CRC_PRESET;
      end else if (is_abort) begin
        if (in_frame && addr_seen) begin
          frame_done    <= 1'b1;
          frame_aborted <= 1'b1;
          fcs_ok        <= 1'b0;
          len_err       <= 1'b0;
        end
        in_frame <= 1'b0;
      end else if (push) begin
        dly <= {dly[5:0], rx_bit};
        if (fill != 3'd7) fill <= fill + 3'd1;
        if (asm_v) begin
          shreg  <= byte_new;
          bitcnt <= bitcnt + 3'd1;
          crc    <= crc_nxt;
        end
        if (byte_done) begin
          if (!addr_seen) begin
            addr_seen <= 1'b1;
            if (!addr_ok) in_frame <= 1'b0;
          end else begin
            if (nb == 2'd3) begin
              out_valid <= 1'b1;
              out_data  <= h0;
              out_sof   <= !sent;
              sent      <= 1'b1;
            end else begin
              nb <= nb + 2'd1;
            end
            h0 <= h1;
            h1 <= h2;
            h2 <= byte_new;
          end
        end
      end
    end
  end

  assert_sof_with_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_sof |-> out_valid);
  assert_eof_with_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_eof |-> (frame_done && !frame_aborted && out_valid));
  assert_abort_not_good_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && frame_aborted) |-> (!fcs_ok && !out_eof));
  assert_done_on_bit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> $past(bit_en));
  assert_quiet_in_hunt_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_frame |=> (!out_valid && !out_eof));
  assert_stuffed_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (stuffed && in_frame) |=> ($stable(dly) && $stable(fill) && $stable(crc)));
  assert_preset_on_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    is_flag |=> (crc == CRC_PRESET && in_frame));

endmodule

// File: tb/hdlc_addr_rx_tb_top.sv
module hdlc_addr_rx_tb_top;
  localparam logic [7:0] STN = 8'h5A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_en = 1'b0, rx_bit = 1'b0, filter_en = 1'b1;
  logic [7:0] station_addr = STN;
  logic out_valid, out_sof, out_eof, frame_done, fcs_ok, len_err, frame_aborted;
  logic [7:0] out_data;

  always #4 clk = ~clk;

  hdlc_addr_rx dut_i (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_bit(rx_bit),
    .station_addr(station_addr), .filter_en(filter_en),
    .out_valid(out_valid), .out_data(out_data), .out_sof(out_sof), .out_eof(out_eof),
    .frame_done(frame_done), .fcs_ok(fcs_ok), .len_err(len_err), .frame_aborted(frame_aborted));

  int tests = 0, fails = 0, done_cnt = 0, tx_ones = 0;
  bit finished = 1'b0;
  logic [7:0] got_q[$];
  bit got_sof[$], got_eof[$];

  always @(negedge clk) if (rst_n) begin
    if (out_valid) begin
      got_q.push_back(out_data); got_sof.push_back(out_sof); got_eof.push_back(out_eof);
    end
    if (frame_done) done_cnt++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] crc_byte(input logic [15:0] c, input logic [7:0] v);
    logic [15:0] r = c;
    for (int i = 0; i < 8; i++) r = (r >> 1) ^ ((r[0] ^ v[i]) ? 16'h8408 : 16'h0000);
    return r;
  endfunction

  function automatic bit addr_pass(input logic [7:0] a);
    return !filter_en || a == STN || a == 8'hFF;
  endfunction

  task automatic send_raw(input logic b);
    repeat ($urandom_range(0, 2)) @(negedge clk);
    bit_en = 1'b1; rx_bit = b;
    @(negedge clk);
    bit_en = 1'b0;
  endtask

  task automatic send_flag();
    for (int i = 0; i < 8; i++) send_raw(i != 0 && i != 7);
    tx_ones = 0;
  endtask

  task automatic send_data_bit(input logic b);
    send_raw(b);
    if (b) begin
      tx_ones++;
      if (tx_ones == 5) begin send_raw(1'b0); tx_ones = 0; end
    end else tx_ones = 0;
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) send_data_bit(v[i]);
  endtask

  task automatic run_frame(input logic [7:0] pl[$], input bit bad_fcs, input int extra);
    logic [15:0] c = 16'hFFFF;
    logic [15:0] fcs;
    bit acc;
    int d0;
    got_q.delete(); got_sof.delete(); got_eof.delete();
    d0 = done_cnt;
    foreach (pl[i]) begin c = crc_byte(c, pl[i]); send_byte(pl[i]); end
    fcs = ~c;
    if (bad_fcs) fcs[3] = ~fcs[3];
    send_byte(fcs[7:0]);
    send_byte(fcs[15:8]);
    for (int i = 0; i < extra; i++) send_data_bit(1'b0);
    send_flag();
    acc = addr_pass(pl[0]);
    if (acc) begin
      chk(frame_done == 1'b1, "R9 done at closing flag", frame_done, 1);
      chk(frame_aborted == 1'b0, "R7 no abort on normal close", frame_aborted, 0);
      chk(len_err == (extra != 0 || pl.size() < 2), "R8 length status", len_err, extra != 0 || pl.size() < 2);
      if (extra == 0) chk(fcs_ok == !bad_fcs, "R6 fcs verdict", fcs_ok, !bad_fcs);
    end else
      chk(frame_done == 1'b0, "R3 filtered frame no done", frame_done, 0);
    @(negedge clk);
    if (acc) begin
      chk(done_cnt == d0 + 1, "R10 one done per frame", done_cnt - d0, 1);
      chk(got_q.size() == pl.size() - 1, "R5 octet count excludes FCS", got_q.size(), pl.size() - 1);
      if (got_q.size() == pl.size() - 1) begin
        foreach (got_q[i]) begin
          if (got_q[i] != pl[i+1]) chk(1'b0, "R4 octet value", got_q[i], pl[i+1]);
          if (got_sof[i] != (i == 0)) chk(1'b0, "R4 sof marker", got_sof[i], i == 0);
          if (got_eof[i] != (i == got_q.size() - 1)) chk(1'b0, "R4 eof marker", got_eof[i], i == got_q.size() - 1);
        end
        if (got_q.size() > 0) chk(1'b1, "R4", 0, 0);
      end
    end else begin
      chk(got_q.size() == 0, "R3 filtered frame no data", got_q.size(), 0);
      chk(done_cnt == d0, "R3 filtered frame no done", done_cnt - d0, 0);
    end
  endtask

  initial begin
    logic [7:0] q[$];
    int d0;
    void'($urandom(32'd4711));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 0 && frame_done == 0, "R1 reset idle", {out_valid, frame_done}, 0);

    d0 = done_cnt;
    repeat (3) send_flag();
    chk(done_cnt == d0 && got_q.size() == 0, "R1 idle flags silent", done_cnt - d0, 0);

    q = '{STN, 8'h13, 8'hFF, 8'h7E, 8'h3E, 8'h1F, 8'hF8};
    run_frame(q, 1'b0, 0);
    q = '{8'hFF, 8'h03, 8'hA5};
    run_frame(q, 1'b0, 0);
    q = '{8'h21, 8'h03, 8'h44};
    run_frame(q, 1'b0, 0);
    filter_en = 1'b0;
    q = '{8'h21, 8'h10, 8'h99};
    run_frame(q, 1'b0, 0);
    filter_en = 1'b1;
    q = '{STN, 8'h77, 8'h88};
    run_frame(q, 1'b1, 0);
    q = '{STN, 8'h01, 8'h02};
    run_frame(q, 1'b0, 0);
    q = '{STN};
    run_frame(q, 1'b0, 0);
    q = '{STN, 8'h5C, 8'hC5};
    run_frame(q, 1'b0, 3);

    send_flag();
    got_q.delete(); got_eof.delete(); got_sof.delete();
    send_byte(STN); send_byte(8'h11); send_byte(8'h22);
    for (int i = 0; i < 7; i++) send_raw(1'b1);
    chk(frame_done && frame_aborted, "R7 abort reported", {frame_done, frame_aborted}, 3);
    chk(!fcs_ok, "R7 abort fcs low", fcs_ok, 0);
    @(negedge clk);
    chk(got_eof.size() == 0, "R7 no eof on abort", got_eof.size(), 0);
    send_raw(1'b1); send_raw(1'b1);
    send_flag();

    for (int n = 0; n < 25; n++) begin
      int len = $urandom_range(1, 10);
      int sel = $urandom_range(0, 3);
      q.delete();
      q.push_back(sel == 0 ? 8'hFF : (sel == 3 ? 8'($urandom_range(0, 255)) : STN));
      for (int k = 0; k < len; k++) q.push_back(8'($urandom_range(0, 255)));
      filter_en = ($urandom_range(0, 4) != 0);
      run_frame(q, $urandom_range(0, 5) == 0, 0);
    end

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule